// File: doc/BRIEF.md
# Row/Column Bit-Plane Transfer Controller

This block models a square array of processing elements at the cycle level. Each element holds a small bit-addressable memory and a single logic-cell flip-flop. A set of global command registers, written through one register write port, selects an operation. The operation then moves a whole word along the rows or along the columns of the array in one clock cycle. In a row access, one source row supplies one bit per column. Each bit is taken from that element's memory at the shared address, or from the element's logic output. The word is then delivered to every selected destination row, except at the column positions that the mask blocks. A column access is the mirror image.

Destinations are either element memories, written at the same shared address, or logic cells. A logic cell sees the delivered bit on its logic input during the active cycle and loads it into its flip-flop at the next edge. The context-switch command is decoded and passed out as a one-cycle pulse, and the block takes no other action on it.

Top module: `plane_xfer_ctrl`

## Requirements
- R1: A write to the operation register (select 0) takes effect in the next cycle only. Encoding: 00 idle, 01 context switch, 10 row access, 11 column access. Unless it is written again, the operation returns to idle after that one active cycle.
- R2: During a context-switch cycle, `ctx_switch` is 1. It is 0 at all other times. No memory, flip-flop or logic input changes because of it.
- R3: In a row access (source-row register, select 3, one-hot), the destination element at row d, column c receives the source row's bit of column c. Element (r,c) is bit r*N+c of every per-element port.
- R4: In a column access (source-column register, select 4, one-hot), the destination element at row r, column d receives the source column's bit of row r.
- R5: The transfer-type register (select 1) selects the source and destination: 00 memory to memory, 01 memory to logic, 10 logic to memory, 11 logic to logic. A memory source is read at the address register (select 2). A logic source is the element's `cell_out` bit. A memory destination is written at the next edge. A logic destination drives `logic_in` in the active cycle and loads its flip-flop at the next edge.
- R6: A masked position receives nothing. Its memory and flip-flop keep their values, and its `logic_in` is 0.
- R7: Elements outside the destination lines are unchanged and present 0 on `logic_in`.
- R8: One register (select 5) holds the destination rows for row accesses and the column-access mask indexed by row. Another register (select 6) holds the destination columns for column accesses and the row-access mask indexed by column. A set bit means destination or masked.
- R9: If the active access's source register has zero set bits or more than one, no element is written and `src_err` becomes 1. Only reset clears it.
- R10: After reset, all memories, flip-flops and registers are 0, and `logic_in`, `ctx_switch` and `src_err` are 0.
- R11: `logic_in` is all zeros in any cycle that is not a valid access with a logic destination.
- R12: A memory-to-memory access reads and writes the same address. Other addresses of the destination elements are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0 op, 1 type, 2 address, 3 source rows, 4 source columns, 5 dest rows / column mask, 6 dest columns / row mask) |
| reg_wdata | input | max(N,AW) | Register write data, LSB aligned |
| cell_out | input | N*N | Logic output bit of each element |
| logic_in | output | N*N | Logic input bit of each element, valid during a delivery |
| cell_ff | output | N*N | Logic-cell flip-flop of each element |
| ctx_switch | output | 1 | Context-switch command pulse |
| src_err | output | 1 | Sticky bad-source flag |

## Verification
The memories are first seeded row by row with logic-to-memory writes at several addresses. Reads from each source row and each source column then show whether the bit taken belongs to the right line position and the right address. Reads with sparse destination sets and with checkerboard masks separate the destination register from the mask register. A column access with the destination-row register non-zero shows that the shared register really acts as a mask. Memory-to-memory copies, read back at the copied address and at an untouched one, tell the address sharing apart from a stray write. A long random mix of types, directions, masks and idle or context-switch cycles, compared every clock against a behavioural model, is followed by empty and double source selects to expose the error path.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'b00,
    OP_CTX  = 2'b01,
    OP_ROW  = 2'b10,
    OP_COL  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    K_M2M = 2'b00,
    K_M2L = 2'b01,
    K_L2M = 2'b10,
    K_L2L = 2'b11
  } kind_e;

  typedef enum logic [2:0] {
    SEL_OP      = 3'd0,
    SEL_KIND    = 3'd1,
    SEL_ADDR    = 3'd2,
    SEL_SRC_ROW = 3'd3,
    SEL_SRC_COL = 3'd4,
    SEL_DST_ROW = 3'd5,
    SEL_DST_COL = 3'd6,
    SEL_NONE    = 3'd7
  } regsel_e;

  // memory is the source for the low two transfer types
  function automatic logic src_is_mem(kind_e k);
    return ~k[1];
  endfunction

  // memory is the destination for the even transfer types
  function automatic logic dst_is_mem(kind_e k);
    return ~k[0];
  endfunction

  // row-major flat index of element (r,c)
  function automatic int unsigned elem_idx(int unsigned r, int unsigned c, int unsigned n);
    return r * n + c;
  endfunction

endpackage

// File: rtl/xfer_cmd_regs.sv
module xfer_cmd_regs
  import xfer_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 4,
  parameter int WD = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  regsel_e       reg_sel,
  input  logic [WD-1:0] reg_wdata,
  output op_e           op_q,
  output kind_e         kind_q,
  output logic [AW-1:0] addr_q,
  output logic [N-1:0]  src_row_q,
  output logic [N-1:0]  src_col_q,
  output logic [N-1:0]  dst_row_q,
  output logic [N-1:0]  dst_col_q,
  output logic          row_acc,
  output logic          col_acc,
  output logic          ctx_pulse
);

  logic op_write;
  assign op_write = reg_we && (reg_sel == SEL_OP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q      <= OP_IDLE;
      kind_q    <= K_M2M;
      addr_q    <= '0;
      src_row_q <= '0;
      src_col_q <= '0;
      dst_row_q <= '0;
      dst_col_q <= '0;
    end else begin
      // one-shot: the command lives for exactly the cycle after its write
      op_q <= op_write ? op_e'(reg_wdata[1:0]) : OP_IDLE;
      if (reg_we) begin
        case (reg_sel)
          SEL_KIND:    kind_q    <= kind_e'(reg_wdata[1:0]);
          SEL_ADDR:    addr_q    <= reg_wdata[AW-1:0];
          SEL_SRC_ROW: src_row_q <= reg_wdata[N-1:0];
          SEL_SRC_COL: src_col_q <= reg_wdata[N-1:0];
          SEL_DST_ROW: dst_row_q <= reg_wdata[N-1:0];
          SEL_DST_COL: dst_col_q <= reg_wdata[N-1:0];
          default: ;
        endcase
      end
    end
  end

  assign row_acc   = (op_q == OP_ROW);
  assign col_acc   = (op_q == OP_COL);
  assign ctx_pulse = (op_q == OP_CTX);

  // R1: a command not refreshed by a new write lapses to idle
  p_op_oneshot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q != OP_IDLE && !op_write) |=> (op_q == OP_IDLE));

endmodule

// File: rtl/xfer_source.sv
module xfer_source #(
  parameter int N = 4
) (
  input  logic           row_acc,
  input  logic           col_acc,
  input  logic           from_mem,
  input  logic [N-1:0]   src_row,
  input  logic [N-1:0]   src_col,
  input  logic [N*N-1:0] mem_bits,
  input  logic [N*N-1:0] cell_bits,
  output logic [N-1:0]   bus,
  output logic           src_ok
);

  localparam int NN = N * N;

  logic [NN-1:0] pick;
  logic [N-1:0]  line_sel;

  assign pick     = from_mem ? mem_bits : cell_bits;
  assign line_sel = col_acc ? src_col : src_row;
  assign src_ok   = (row_acc || col_acc) && ($countones(line_sel) == 1);

  // bus position k gathers the bit of the selected line at position k
  always_comb begin
    bus = '0;
    for (int k = 0; k < N; k++) begin
      for (int j = 0; j < N; j++) begin
        if (row_acc)
          bus[k] = bus[k] | (line_sel[j] & pick[j*N + k]);
        else
          bus[k] = bus[k] | (line_sel[j] & pick[k*N + j]);
      end
    end
  end

endmodule

// File: rtl/xfer_cell.sv
module xfer_cell #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          mem_we,
  input  logic          log_we,
  input  logic          bit_in,
  output logic          mem_bit,
  output logic          ff_q,
  output logic          logic_in
);

  localparam int DEPTH = 1 << AW;

  logic [DEPTH-1:0] store;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      store <= '0;
      ff_q  <= 1'b0;
    end else begin
      if (mem_we) store[addr] <= bit_in;
      if (log_we) ff_q <= bit_in;
    end
  end

  assign mem_bit  = store[addr];
  assign logic_in = log_we & bit_in;

  // R5: a memory delivery lands at the address of its cycle
  p_mem_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (store[$past(addr)] == $past(bit_in)));

  // R5: a logic delivery is held by the flip-flop afterwards
  p_ff_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    log_we |=> (ff_q == $past(bit_in)));

endmodule

// File: rtl/plane_xfer_ctrl.sv
module plane_xfer_ctrl
  import xfer_pkg::*;
#(
  parameter int N  = 4,
  parameter int AW = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_we,
  input  logic [2:0]                     reg_sel,
  input  logic [((N > AW) ? N : AW)-1:0] reg_wdata,
  input  logic [N*N-1:0]                 cell_out,
  output logic [N*N-1:0]                 logic_in,
  output logic [N*N-1:0]                 cell_ff,
  output logic                           ctx_switch,
  output logic                           src_err
);

  localparam int WD = (N > AW) ? N : AW;
  localparam int NN = N * N;

  op_e           op_q;
  kind_e         kind_q;
  logic [AW-1:0] addr_q;
  logic [N-1:0]  src_row_q, src_col_q, dst_row_q, dst_col_q;
  logic          row_acc, col_acc, ctx_pulse;
  logic [N-1:0]  bus;
  logic          src_ok;
  logic [NN-1:0] mem_bits;
  logic [NN-1:0] mem_we_v, log_we_v;

  xfer_cmd_regs #(.N(N), .AW(AW), .WD(WD)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(regsel_e'(reg_sel)),
    .reg_wdata(reg_wdata), .op_q(op_q), .kind_q(kind_q), .addr_q(addr_q),
    .src_row_q(src_row_q), .src_col_q(src_col_q), .dst_row_q(dst_row_q),
    .dst_col_q(dst_col_q), .row_acc(row_acc), .col_acc(col_acc),
    .ctx_pulse(ctx_pulse)
  );

  xfer_source #(.N(N)) u_src (
    .row_acc(row_acc), .col_acc(col_acc), .from_mem(src_is_mem(kind_q)),
    .src_row(src_row_q), .src_col(src_col_q), .mem_bits(mem_bits),
    .cell_bits(cell_out), .bus(bus), .src_ok(src_ok)
  );

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      localparam int E = r * N + c;
      logic en, bitv;
      // select 5 = dest rows / column mask, select 6 = dest columns / row mask
      assign en = src_ok && (row_acc ? (dst_row_q[r] & ~dst_col_q[c])
                                     : (dst_col_q[c] & ~dst_row_q[r]));
      assign bitv        = row_acc ? bus[c] : bus[r];
      assign mem_we_v[E] = en &  dst_is_mem(kind_q);
      assign log_we_v[E] = en & ~dst_is_mem(kind_q);

      xfer_cell #(.AW(AW)) u_cell (
        .clk(clk), .rst_n(rst_n), .addr(addr_q), .mem_we(mem_we_v[E]),
        .log_we(log_we_v[E]), .bit_in(bitv), .mem_bit(mem_bits[E]),
        .ff_q(cell_ff[E]), .logic_in(logic_in[E])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) src_err <= 1'b0;
    else if ((row_acc || col_acc) && !src_ok) src_err <= 1'b1;
  end

  assign ctx_switch = ctx_pulse;

  // R9: the error flag never clears outside reset
  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    src_err |=> src_err);

  // R9: a bad source select blocks every delivery
  p_bad_src_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((row_acc || col_acc) && !src_ok) |-> (mem_we_v == '0 && log_we_v == '0));

  // R2: a context-switch cycle delivers nothing
  p_ctx_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_switch |-> (mem_we_v == '0 && logic_in == '0));

  // R11: no logic input outside an access cycle
  p_idle_logic_in_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(row_acc || col_acc) |-> (logic_in == '0));

endmodule

// File: tb/sim_plane_xfer_ctrl.sv
`timescale 1ns/1ps
module sim_plane_xfer_ctrl;

  localparam int N = 4, AW = 4, NN = N * N, DEPTH = 1 << AW;
  localparam int WD = (N > AW) ? N : AW;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [2:0] reg_sel = 0;
  logic [WD-1:0] reg_wdata = 0;
  logic [NN-1:0] cell_out = 0;
  logic [NN-1:0] logic_in, cell_ff;
  logic ctx_switch, src_err;

  always #4 clk = ~clk;

  plane_xfer_ctrl #(.N(N), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .cell_out(cell_out), .logic_in(logic_in),
    .cell_ff(cell_ff), .ctx_switch(ctx_switch), .src_err(src_err)
  );

  int tests = 0, fails = 0, cyc = 0;
  string cur_req = "R10";

  // behavioural reference state
  int m_op, m_kind, m_addr;
  bit [N-1:0] m_srow, m_scol, m_drow, m_dcol;
  bit m_mem [NN][DEPTH];
  bit m_ff [NN];
  bit m_err;

  function automatic void plan(output bit [NN-1:0] en, output bit [NN-1:0] val,
                               output bit ok, output bit access);
    bit [N-1:0] s;
    int cnt = 0, line = 0;
    en = 0; val = 0;
    access = (m_op == 2 || m_op == 3);
    s = (m_op == 3) ? m_scol : m_srow;
    for (int i = 0; i < N; i++) if (s[i]) begin cnt++; line = i; end
    ok = access && cnt == 1;
    if (!ok) return;
    for (int d = 0; d < N; d++) begin
      for (int p = 0; p < N; p++) begin
        int dst, src;
        bit sel, masked;
        if (m_op == 2) begin
          dst = d * N + p; src = line * N + p; sel = m_drow[d]; masked = m_dcol[p];
        end else begin
          dst = p * N + d; src = p * N + line; sel = m_dcol[d]; masked = m_drow[p];
        end
        if (sel && !masked) begin
          en[dst] = 1;
          val[dst] = (m_kind < 2) ? m_mem[src][m_addr] : cell_out[src];
        end
      end
    end
  endfunction

  always @(posedge clk) begin
    bit [NN-1:0] en, val;
    bit ok, acc;
    cyc++;
    if (!rst_n) begin
      m_op = 0; m_kind = 0; m_addr = 0; m_err = 0;
      m_srow = 0; m_scol = 0; m_drow = 0; m_dcol = 0;
      for (int e = 0; e < NN; e++) begin
        m_ff[e] = 0;
        for (int a = 0; a < DEPTH; a++) m_mem[e][a] = 0;
      end
    end else begin
      plan(en, val, ok, acc);
      if (acc && !ok) m_err = 1;
      for (int e = 0; e < NN; e++)
        if (en[e]) begin
          if (m_kind % 2 == 0) m_mem[e][m_addr] = val[e];
          else m_ff[e] = val[e];
        end
      m_op = (reg_we && reg_sel == 0) ? int'(reg_wdata[1:0]) : 0;
      if (reg_we)
        case (reg_sel)
          1: m_kind = int'(reg_wdata[1:0]);
          2: m_addr = int'(reg_wdata[AW-1:0]);
          3: m_srow = reg_wdata[N-1:0];
          4: m_scol = reg_wdata[N-1:0];
          5: m_drow = reg_wdata[N-1:0];
          6: m_dcol = reg_wdata[N-1:0];
          default: ;
        endcase
    end
  end

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  // compare against the model in the middle of every cycle
  always @(negedge clk) begin
    bit [NN-1:0] en, val, exp_li, exp_ff;
    bit ok, acc;
    if (rst_n) begin
      plan(en, val, ok, acc);
      exp_li = (ok && m_kind % 2 == 1) ? (en & val) : '0;
      for (int e = 0; e < NN; e++) exp_ff[e] = m_ff[e];
      chk("logic_in", 64'(logic_in), 64'(exp_li));
      chk("cell_ff", 64'(cell_ff), 64'(exp_ff));
      chk("ctx_switch", 64'(ctx_switch), 64'(m_op == 1));
      chk("src_err", 64'(src_err), 64'(m_err));
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic wr(int sel, int val);
    reg_we = 1; reg_sel = sel[2:0]; reg_wdata = val[WD-1:0];
    @(posedge clk); #2;
    reg_we = 0;
  endtask

  task automatic op(int o);
    wr(0, o);
    step(1);
  endtask

  task automatic setup(int kind, int addr, int srow, int scol, int drow, int dcol);
    wr(1, kind); wr(2, addr); wr(3, srow); wr(4, scol); wr(5, drow); wr(6, dcol);
  endtask

  initial begin
    step(3);
    rst_n = 1;
    // R10: reset state visible at the ports
    cur_req = "R10";
    step(1);
    chk("reset logic_in", 64'(logic_in), 0);
    chk("reset cell_ff", 64'(cell_ff), 0);
    chk("reset flags", 64'({ctx_switch, src_err}), 0);
    step(2);

    // R5 logic-to-memory: seed each row at four addresses
    cur_req = "R5";
    for (int a = 0; a < 4; a++)
      for (int r = 0; r < N; r++) begin
        cell_out = NN'($urandom);
        setup(2, a, 1 << r, 0, 1 << r, 0);
        op(2);
      end

    // R3: row reads from each source row into all rows
    cur_req = "R3";
    for (int a = 0; a < 4; a++)
      for (int r = 0; r < N; r++) begin setup(1, a, 1 << r, 0, 4'hF, 0); op(2); end

    // R4: column reads from each source column into all columns
    cur_req = "R4";
    for (int c = 0; c < N; c++) begin setup(1, c, 0, 1 << c, 0, 4'hF); op(3); end

    // R6: masked columns in a row read
    cur_req = "R6";
    setup(1, 1, 4'h2, 0, 4'hF, 4'h5); op(2);
    setup(3, 0, 4'h1, 0, 4'hF, 4'hA); cell_out = 16'hFFFF; op(2);

    // R7: sparse destination rows
    cur_req = "R7";
    setup(1, 2, 4'h4, 0, 4'h9, 0); op(2);
    setup(3, 0, 0, 4'h1, 0, 4'h6); cell_out = 16'h0000; op(3);

    // R8: destination-row register masks rows in a column access
    cur_req = "R8";
    setup(1, 3, 0, 4'h2, 4'h3, 4'hF); op(3);
    setup(3, 0, 0, 4'h8, 4'h5, 4'hF); cell_out = 16'hFFFF; op(3);

    // R12: memory-to-memory copy at one address, read back two addresses
    cur_req = "R12";
    setup(0, 2, 4'h1, 0, 4'h8, 0); op(2);
    setup(1, 2, 4'h8, 0, 4'hF, 0); op(2);
    setup(1, 3, 4'h8, 0, 4'hF, 0); op(2);
    setup(0, 1, 0, 4'h4, 0, 4'h1); op(3);
    setup(1, 1, 0, 4'h1, 0, 4'hF); op(3);

    // R2: context switch pulse and no side effect
    cur_req = "R2";
    op(1); step(2);

    // R1: one-shot command and back-to-back commands
    cur_req = "R1";
    setup(3, 0, 4'h1, 0, 4'hF, 0); cell_out = 16'h1234;
    wr(0, 2); wr(0, 2); step(3);
    wr(0, 0); step(1);

    // R11: random mixed traffic with idle and context cycles
    cur_req = "R11";
    for (int i = 0; i < 300; i++) begin
      cell_out = NN'($urandom);
      setup($urandom % 4, $urandom % DEPTH, 1 << ($urandom % N), 1 << ($urandom % N),
            $urandom % 16, $urandom % 16);
      op($urandom % 4);
    end

    // R9: empty and double source selects
    cur_req = "R9";
    setup(1, 0, 0, 0, 4'hF, 0); op(2); step(2);
    chk("err after empty source", 64'(src_err), 1);
    setup(2, 5, 4'h3, 0, 4'hF, 0); cell_out = 16'hFFFF; op(2);
    setup(1, 5, 0, 4'h6, 0, 4'hF); op(3);
    setup(1, 5, 4'h1, 0, 4'hF, 0); op(2); step(2);
    chk("err remains", 64'(src_err), 1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    if (cyc > 100000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule